// File: doc/BRIEF.md
# Signed Sum-of-Products Sequencer

This block walks two arrays in memory and accumulates the signed products of their elements. Software loads a multiplicand pointer, a multiplier pointer, a term count and a starting accumulator value, picks byte or word element size, and pulses start. The sequencer then reads one element from each array, multiplies them, and adds the product to the accumulator. It repeats this until the count is exhausted. The pointers, the count and the accumulator are architectural registers. They hold a consistent value after every completed term, so an interrupt can be taken at the accept point that follows each addition.

In word mode the elements are 16-bit and the accumulator is 32 bits wide. In byte mode the elements are 8-bit and only the low 16 bits of the accumulator take part. If an addition would leave the signed range of the active accumulator, the loop stops at once and the overflow flag is raised. The registers then show the state from before the failing term.

The controller has four states. IDLE waits for start. FETCH_A requests the multiplicand. FETCH_B captures the multiplicand and requests the multiplier. MAC multiplies, adds and commits. The transitions are:
- IDLE→FETCH_A on start with a nonzero count.
- IDLE→IDLE on start with a zero count; done still pulses.
- FETCH_A→FETCH_B and FETCH_B→MAC unconditionally.
- MAC→FETCH_A while terms remain.
- MAC→IDLE on overflow or after the last term.

Top module: `sop_engine`

## Requirements
- R1: A start pulse in IDLE loads ptr_a, ptr_b, count and acc from the inputs and raises busy from the next cycle. A start pulse while busy is ignored.
- R2: In word mode (word_mode=1) each term adds the signed 16×16 product to the full 32-bit accumulator. A word read at address n returns mem[n] in bits 7:0 and mem[n+1] in bits 15:8.
- R3: In byte mode (word_mode=0) each term adds the signed 8×8 product of bits 7:0 of each read to acc[15:0]. acc[31:16] stays unchanged.
- R4: After each committed term both pointers advance by the element size (1 or 2, wrapping modulo 2^16) and count decreases by one. The loop ends when count reaches zero.
- R5: If a sum is not representable in the active signed accumulator width, ovf is set, done pulses, busy drops, and acc, pointers and count keep their values from before that term. ovf is cleared by the next accepted start.
- R6: A start with count_in = 0 issues no memory read, loads the inputs unchanged, clears ovf and pulses done in the next cycle.
- R7: Each term takes three cycles. mem_req is high with mem_addr = ptr_a in the first cycle and with mem_addr = ptr_b in the second. Read data is returned on mem_rdata the cycle after the request.
- R8: int_ok pulses for one cycle after every successfully committed addition and at no other time.
- R9: done pulses for one cycle when the loop finishes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled in IDLE) |
| word_mode | input | 1 | 1 = 16-bit elements, 0 = 8-bit elements |
| ptr_a_in | input | 16 | Initial multiplicand address |
| ptr_b_in | input | 16 | Initial multiplier address |
| count_in | input | 16 | Number of terms |
| acc_in | input | 32 | Initial accumulator value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| ptr_a | output | 16 | Current multiplicand pointer |
| ptr_b | output | 16 | Current multiplier pointer |
| count | output | 16 | Remaining terms |
| acc | output | 32 | Accumulator |
| ovf | output | 1 | Overflow stop flag |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| int_ok | output | 1 | One-cycle interrupt accept point |

## Verification
A wrong state or a missed transition in the controller shows up as a mismatch on mem_req or mem_addr within one cycle. A wrong multiplicand latch or sign extension corrupts acc at the MAC commit, three cycles after the term begins. A wrong pointer step or count decrement becomes visible at the same commit edge. An error in overflow detection shows up as ovf, done or an unchanged accumulator on the edge where the failing term would have committed. Because the reference model is compared every clock, any divergence is reported in the first cycle it reaches a port.

// File: rtl/sop_pkg.sv
package sop_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_FETCH_A = 2'd1,
        S_FETCH_B = 2'd2,
        S_MAC     = 2'd3
    } sop_state_e;
endpackage

// File: rtl/sop_mul.sv
module sop_mul #(
    parameter int BYTE_W = 8
) (
    input  logic                  wide,
    input  logic [2*BYTE_W-1:0]   op_a,
    input  logic [2*BYTE_W-1:0]   op_b,
    output logic [4*BYTE_W-1:0]   prod
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ACC_W  = 4 * BYTE_W;

    logic signed [WORD_W-1:0] a_nar, b_nar, p_nar;
    logic signed [ACC_W-1:0]  a_wid, b_wid, p_wid;

    always_comb begin
        a_nar = {{BYTE_W{op_a[BYTE_W-1]}}, op_a[BYTE_W-1:0]};
        b_nar = {{BYTE_W{op_b[BYTE_W-1]}}, op_b[BYTE_W-1:0]};
        a_wid = {{WORD_W{op_a[WORD_W-1]}}, op_a};
        b_wid = {{WORD_W{op_b[WORD_W-1]}}, op_b};
        p_nar = a_nar * b_nar;
        p_wid = a_wid * b_wid;
        if (wide) prod = p_wid;
        else      prod = {{WORD_W{p_nar[WORD_W-1]}}, p_nar};
    end
endmodule

// File: rtl/sop_acc.sv
module sop_acc #(
    parameter int BYTE_W = 8
) (
    input  logic                wide,
    input  logic [4*BYTE_W-1:0] acc_cur,
    input  logic [4*BYTE_W-1:0] prod,
    output logic [4*BYTE_W-1:0] acc_next,
    output logic                ovf
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ACC_W  = 4 * BYTE_W;

    logic [ACC_W:0]  sum_w;
    logic [WORD_W:0] sum_n;

    always_comb begin
        sum_w = {acc_cur[ACC_W-1], acc_cur} + {prod[ACC_W-1], prod};
        sum_n = {acc_cur[WORD_W-1], acc_cur[WORD_W-1:0]} + {prod[WORD_W-1], prod[WORD_W-1:0]};
        if (wide) begin
            acc_next = sum_w[ACC_W-1:0];
            ovf      = sum_w[ACC_W] ^ sum_w[ACC_W-1];
        end else begin
            acc_next = {acc_cur[ACC_W-1:WORD_W], sum_n[WORD_W-1:0]};
            ovf      = sum_n[WORD_W] ^ sum_n[WORD_W-1];
        end
    end
endmodule

// File: rtl/sop_engine.sv
module sop_engine
    import sop_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                word_mode,
    input  logic [ADDR_W-1:0]   ptr_a_in,
    input  logic [ADDR_W-1:0]   ptr_b_in,
    input  logic [CNT_W-1:0]    count_in,
    input  logic [4*BYTE_W-1:0] acc_in,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [2*BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0]   ptr_a,
    output logic [ADDR_W-1:0]   ptr_b,
    output logic [CNT_W-1:0]    count,
    output logic [4*BYTE_W-1:0] acc,
    output logic                ovf,
    output logic                done,
    output logic                busy,
    output logic                int_ok
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ACC_W  = 4 * BYTE_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    sop_state_e state_q, state_d;

    logic [ADDR_W-1:0] pa_q, pb_q, step;
    logic [CNT_W-1:0]  cnt_q;
    logic [ACC_W-1:0]  acc_q, acc_sum, prod;
    logic [WORD_W-1:0] opa_q;
    logic              wide_q, ovf_q, done_q, ok_q, add_ovf;

    sop_mul #(.BYTE_W(BYTE_W)) u_mul (
        .wide (wide_q),
        .op_a (opa_q),
        .op_b (mem_rdata),
        .prod (prod)
    );

    sop_acc #(.BYTE_W(BYTE_W)) u_acc (
        .wide     (wide_q),
        .acc_cur  (acc_q),
        .prod     (prod),
        .acc_next (acc_sum),
        .ovf      (add_ovf)
    );

    assign step = wide_q ? ADDR_W'(2) : ADDR_W'(1);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start && count_in != '0) state_d = S_FETCH_A;
            S_FETCH_A: state_d = S_FETCH_B;
            S_FETCH_B: state_d = S_MAC;
            S_MAC:     if (add_ovf || cnt_q == CNT_ONE) state_d = S_IDLE;
                       else                             state_d = S_FETCH_A;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = pa_q;
        unique case (state_q)
            S_IDLE:    ;
            S_FETCH_A: mem_req = 1'b1;
            S_FETCH_B: begin mem_req = 1'b1; mem_addr = pb_q; end
            S_MAC:     ;
        endcase
    end

    // Architectural registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q <= '0; pb_q <= '0; cnt_q <= '0; acc_q <= '0; opa_q <= '0;
            wide_q <= 1'b0; ovf_q <= 1'b0; done_q <= 1'b0; ok_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ok_q   <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    pa_q   <= ptr_a_in;
                    pb_q   <= ptr_b_in;
                    cnt_q  <= count_in;
                    acc_q  <= acc_in;
                    wide_q <= word_mode;
                    ovf_q  <= 1'b0;
                    if (count_in == '0) done_q <= 1'b1;
                end
                S_FETCH_A: ;
                S_FETCH_B: opa_q <= mem_rdata;
                S_MAC: if (add_ovf) begin
                    ovf_q  <= 1'b1;
                    done_q <= 1'b1;
                end else begin
                    acc_q <= acc_sum;
                    pa_q  <= pa_q + step;
                    pb_q  <= pb_q + step;
                    cnt_q <= cnt_q - CNT_ONE;
                    ok_q  <= 1'b1;
                    if (cnt_q == CNT_ONE) done_q <= 1'b1;
                end
            endcase
        end
    end

    assign ptr_a  = pa_q;
    assign ptr_b  = pb_q;
    assign count  = cnt_q;
    assign acc    = acc_q;
    assign ovf    = ovf_q;
    assign done   = done_q;
    assign busy   = (state_q != S_IDLE);
    assign int_ok = ok_q;

    // Assertions
    a_r7_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && count != $past(count)) |-> count == $past(count) - CNT_ONE);
    a_r5_ovf_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (done && !busy && !int_ok));
    a_r8_accept_after_mac: assert property (@(posedge clk) disable iff (rst)
        int_ok |-> $past(state_q) == S_MAC);
    a_r3_high_half_kept: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && !wide_q) |-> acc[ACC_W-1:WORD_W] == $past(acc[ACC_W-1:WORD_W]));
    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/sop_engine_tb.sv
module sop_engine_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, word_mode = 1'b0;
    logic [15:0] ptr_a_in = '0, ptr_b_in = '0, count_in = '0;
    logic [31:0] acc_in = '0;
    logic        mem_req;
    logic [15:0] mem_addr, mem_rdata;
    logic [15:0] ptr_a, ptr_b, count;
    logic [31:0] acc;
    logic        ovf, done, busy, int_ok;

    always #4 clk = ~clk; // 125 MHz

    sop_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .word_mode(word_mode),
        .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .count_in(count_in), .acc_in(acc_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ptr_a(ptr_a), .ptr_b(ptr_b), .count(count), .acc(acc),
        .ovf(ovf), .done(done), .busy(busy), .int_ok(int_ok)
    );

    logic [7:0] mem [0:255];
    initial mem_rdata = '0;
    always @(posedge clk)
        if (mem_req) mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};

    int vectors = 0, errors = 0;

    // Behavioural reference model
    logic [15:0] m_pa, m_pb, m_cnt;
    logic [31:0] m_acc;
    logic        m_wide, m_ovf, m_done, m_busy, m_ok, m_zero;
    int          m_ph;

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return {mem[8'(a[7:0] + 8'd1)], mem[a[7:0]]};
    endfunction

    task automatic model_term();
        longint av, bv, s;
        logic [15:0] ra, rb;
        bit fits;
        ra = rd16(m_pa); rb = rd16(m_pb);
        if (m_wide) begin
            av = longint'($signed(ra)); bv = longint'($signed(rb));
            s = longint'($signed(m_acc)) + av * bv;
            fits = (s >= -64'sd2147483648) && (s <= 64'sd2147483647);
        end else begin
            av = longint'($signed(ra[7:0])); bv = longint'($signed(rb[7:0]));
            s = longint'($signed(m_acc[15:0])) + av * bv;
            fits = (s >= -64'sd32768) && (s <= 64'sd32767);
        end
        if (!fits) begin
            m_ovf = 1; m_done = 1; m_busy = 0;
        end else begin
            if (m_wide) m_acc = s[31:0];
            else        m_acc[15:0] = s[15:0];
            m_pa = m_pa + (m_wide ? 16'd2 : 16'd1);
            m_pb = m_pb + (m_wide ? 16'd2 : 16'd1);
            m_cnt = m_cnt - 16'd1;
            m_ok = 1;
            if (m_cnt == 0) begin m_done = 1; m_busy = 0; end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_pa = 0; m_pb = 0; m_cnt = 0; m_acc = 0; m_wide = 0;
            m_ovf = 0; m_done = 0; m_busy = 0; m_ok = 0; m_ph = 0; m_zero = 0;
        end else begin
            m_done = 0; m_ok = 0;
            if (!m_busy) begin
                if (start) begin
                    m_pa = ptr_a_in; m_pb = ptr_b_in; m_cnt = count_in; m_acc = acc_in;
                    m_wide = word_mode; m_ovf = 0;
                    m_zero = (count_in == 0);
                    if (count_in == 0) m_done = 1;
                    else begin m_busy = 1; m_ph = 0; end
                end
            end else begin
                m_ph++;
                if (m_ph == 3) begin m_ph = 0; model_term(); end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!rst) begin
        chk(m_wide ? "R2" : "R3", "acc", acc, m_acc);
        chk("R4", "ptr_a", {16'h0, ptr_a}, {16'h0, m_pa});
        chk("R4", "ptr_b", {16'h0, ptr_b}, {16'h0, m_pb});
        chk("R4", "count", {16'h0, count}, {16'h0, m_cnt});
        chk("R5", "ovf", {31'h0, ovf}, {31'h0, m_ovf});
        chk(m_zero ? "R6" : "R9", "done", {31'h0, done}, {31'h0, m_done});
        chk("R1", "busy", {31'h0, busy}, {31'h0, m_busy});
        chk("R8", "int_ok", {31'h0, int_ok}, {31'h0, m_ok});
        chk("R7", "mem_req", {31'h0, mem_req}, {31'h0, m_busy && m_ph < 2});
        if (m_busy && m_ph < 2)
            chk("R7", "mem_addr", {16'h0, mem_addr}, {16'h0, (m_ph == 0) ? m_pa : m_pb});
    end

    task automatic setw(input logic [15:0] a, input logic [15:0] v);
        mem[a[7:0]] = v[7:0]; mem[8'(a[7:0] + 8'd1)] = v[15:8];
    endtask

    task automatic run(input logic w, input logic [15:0] pa, input logic [15:0] pb,
                       input logic [15:0] n, input logic [31:0] a0);
        @(negedge clk);
        word_mode = w; ptr_a_in = pa; ptr_b_in = pb; count_in = n; acc_in = a0; start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state: all zero, idle
        chk("R1", "reset acc", acc, 32'h0);
        // R2 word mode, mixed signs
        setw(16'h10, 16'd1000); setw(16'h12, -16'sd2000); setw(16'h14, 16'd300);
        setw(16'h40, 16'd30000); setw(16'h42, 16'd15);    setw(16'h44, -16'sd7);
        run(1, 16'h10, 16'h40, 3, 32'h0000_0100);
        // R3 byte mode, high half preserved
        mem[8'h80] = 8'h80; mem[8'h81] = 8'd5; mem[8'h82] = 8'd127; mem[8'h83] = 8'hFD;
        mem[8'h90] = 8'h80; mem[8'h91] = 8'hF9; mem[8'h92] = 8'd2;  mem[8'h93] = 8'd100;
        run(0, 16'h80, 16'h90, 4, 32'hABCD_0010);
        // R6 zero count
        run(1, 16'h1234, 16'h5678, 0, 32'hDEAD_BEEF);
        // R5 word overflow on second term
        setw(16'h20, 16'd100); setw(16'h22, 16'd32767);
        setw(16'h50, 16'd100); setw(16'h52, 16'd32767);
        run(1, 16'h20, 16'h50, 2, 32'h7FFF_0000);
        // R5 byte overflow on first term, then ovf cleared by R6 start
        mem[8'hA0] = 8'd127; mem[8'hB0] = 8'd127;
        run(0, 16'hA0, 16'hB0, 2, 32'h0000_7000);
        run(0, 16'h0, 16'h0, 0, 32'h1);
        // R4 pointer wrap in byte mode
        run(0, 16'hFFFF, 16'h0020, 3, 32'h5555_0000);
        // R2 odd word address
        run(1, 16'h31, 16'h61, 2, 32'hFFFF_FFF0);
        // R1 start while busy is ignored
        @(negedge clk);
        word_mode = 1; ptr_a_in = 16'h10; ptr_b_in = 16'h40; count_in = 3; acc_in = 0; start = 1;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        word_mode = 0; ptr_a_in = 16'h99; ptr_b_in = 16'h77; count_in = 9; acc_in = 32'h1; start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule